// File: doc/BRIEF.md
# PHY Status LED Controller

This block turns the activity and state indications of a 10/100 Ethernet PHY into the drive levels for five active-low status LEDs: transmit, receive, collision, link/traffic and duplex/polarity. Transmit, receive and collision events can last a single clock cycle. Each one is stretched by a retriggerable one-shot timer, so that even the shortest event lights its LED for long enough to be seen.

Two mode bits change what two of the pins mean. With the traffic mode bit set, the link pin stays lit while the link is good and goes dark briefly on each transmit or receive event. Steady activity therefore makes it blink. With the polarity mode bit set, the duplex pin lights when the receive polarity is inverted, in place of showing full duplex. The stretch time and the flash half-period are cycle-count parameters. Their defaults give about 50 ms at a 25 MHz clock.

Top module: `phy_led_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the transmit, receive and collision outputs are high (LED off), and every timer is cleared.
- R2: A transmit event sampled at a rising edge drives the transmit output low from that edge for exactly STRETCH_CYCLES cycles. The output is high otherwise.
- R3: A receive event drives the receive output low in the same way as R2, for exactly STRETCH_CYCLES cycles.
- R4: A new event arriving while a stretch is running restarts that stretch at its full length.
- R5: A collision event lights the collision output for STRETCH_CYCLES cycles. While full duplex is high, the collision output is forced high, and collision events in that cycle start no stretch.
- R6: With the traffic mode bit low, the link output is low exactly when the link-good input is high.
- R7: With the traffic mode bit high and the link good, a transmit or receive event at an edge where no flash is running starts a flash. The link output goes high for FLASH_CYCLES cycles and then low for FLASH_CYCLES + 1 cycles. Events that arrive during a flash are ignored. Without a good link the output is high.
- R8: Continuous transmit or receive activity in traffic mode makes the link output blink repeatedly with a period of 2*FLASH_CYCLES + 1 cycles.
- R9: With the polarity mode bit low, the duplex output is low exactly when full duplex is high.
- R10: With the polarity mode bit high, the duplex output is low exactly when polarity-inverted is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txAct | input | 1 | Transmit activity event |
| rxAct | input | 1 | Receive activity event |
| colAct | input | 1 | Collision event |
| linkGood | input | 1 | Link is up |
| fullDuplex | input | 1 | Full duplex is in effect |
| polInverted | input | 1 | Receive polarity is inverted |
| trafficMode | input | 1 | Link pin shows traffic |
| polLedMode | input | 1 | Duplex pin shows polarity |
| txLedN | output | 1 | Transmit LED, active low |
| rxLedN | output | 1 | Receive LED, active low |
| colLedN | output | 1 | Collision LED, active low |
| linkLedN | output | 1 | Link/traffic LED, active low |
| fdxLedN | output | 1 | Duplex/polarity LED, active low |

## Verification
Two functions can act in the same cycle. A collision can be sampled while full duplex is rising or falling, and a flash can be starting while the mode bit or the link flips. Both can also meet a retrigger of a stretch that is already running. The random stimulus toggles full duplex, link and traffic mode at a low rate on top of frequent activity events, so these coincidences happen many times. Directed phases also place a retrigger one cycle before a stretch expires and keep activity held high through several flash periods. A cycle-level model written from the requirements judges every output on every cycle.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  // Strobes from the control to the timer datapath, valid for one clock cycle
  typedef struct packed {
    logic txKick;
    logic rxKick;
    logic colKick;
    logic flashKick;
  } ledStrobes_t;

  localparam int NUM_STRETCH = 3;
  localparam int IDX_TX  = 0;
  localparam int IDX_RX  = 1;
  localparam int IDX_COL = 2;
endpackage

// File: rtl/phy_led_timers.sv
module phy_led_timers
  import phy_led_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1250000,
  parameter int FLASH_CYCLES   = 1250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ledStrobes_t strobes,
  output logic [NUM_STRETCH-1:0] stretchOn,
  output logic        flashDark,
  output logic        flashIdle
);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam int FW = $clog2(2 * FLASH_CYCLES + 1);
  localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYCLES);
  localparam logic [FW-1:0] FLASH_LOAD   = FW'(2 * FLASH_CYCLES);
  localparam logic [FW-1:0] FLASH_HALF   = FW'(FLASH_CYCLES);

  logic [NUM_STRETCH-1:0] kickVec;
  assign kickVec[IDX_TX]  = strobes.txKick;
  assign kickVec[IDX_RX]  = strobes.rxKick;
  assign kickVec[IDX_COL] = strobes.colKick;

  genvar g;
  generate
    for (g = 0; g < NUM_STRETCH; g++) begin : gStretch
      logic [SW-1:0] remain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             remain <= '0;
        else if (kickVec[g])   remain <= STRETCH_LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
      end
      assign stretchOn[g] = (remain != '0);
    end
  endgenerate

  logic [FW-1:0] flashCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flashCnt <= '0;
    else if (strobes.flashKick) flashCnt <= FLASH_LOAD;
    else if (flashCnt != '0)    flashCnt <= flashCnt - 1'b1;
  end

  assign flashIdle = (flashCnt == '0);
  assign flashDark = (flashCnt > FLASH_HALF);
endmodule

// File: rtl/phy_led_ctrl_unit.sv
module phy_led_ctrl_unit
  import phy_led_pkg::*;
(
  input  logic        txAct,
  input  logic        rxAct,
  input  logic        colAct,
  input  logic        linkGood,
  input  logic        fullDuplex,
  input  logic        polInverted,
  input  logic        trafficMode,
  input  logic        polLedMode,
  input  logic [NUM_STRETCH-1:0] stretchOn,
  input  logic        flashDark,
  input  logic        flashIdle,
  output ledStrobes_t strobes,
  output logic        txLedN,
  output logic        rxLedN,
  output logic        colLedN,
  output logic        linkLedN,
  output logic        fdxLedN
);
  logic anyTraffic;
  assign anyTraffic = txAct | rxAct;

  always_comb begin
    strobes.txKick    = txAct;
    strobes.rxKick    = rxAct;
    strobes.colKick   = colAct & ~fullDuplex;
    strobes.flashKick = trafficMode & linkGood & anyTraffic & flashIdle;
  end

  logic linkLit;
  always_comb begin
    if (trafficMode) linkLit = linkGood & ~flashDark;
    else             linkLit = linkGood;
  end

  assign txLedN   = ~stretchOn[IDX_TX];
  assign rxLedN   = ~stretchOn[IDX_RX];
  assign colLedN  = ~(stretchOn[IDX_COL] & ~fullDuplex);
  assign linkLedN = ~linkLit;
  assign fdxLedN  = polLedMode ? ~polInverted : ~fullDuplex;
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1250000,
  parameter int FLASH_CYCLES   = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txAct,
  input  logic rxAct,
  input  logic colAct,
  input  logic linkGood,
  input  logic fullDuplex,
  input  logic polInverted,
  input  logic trafficMode,
  input  logic polLedMode,
  output logic txLedN,
  output logic rxLedN,
  output logic colLedN,
  output logic linkLedN,
  output logic fdxLedN
);
  ledStrobes_t strobes;
  logic [NUM_STRETCH-1:0] stretchOn;
  logic flashDark;
  logic flashIdle;

  phy_led_ctrl_unit ctrl_i (
    .txAct(txAct), .rxAct(rxAct), .colAct(colAct), .linkGood(linkGood),
    .fullDuplex(fullDuplex), .polInverted(polInverted),
    .trafficMode(trafficMode), .polLedMode(polLedMode),
    .stretchOn(stretchOn), .flashDark(flashDark), .flashIdle(flashIdle),
    .strobes(strobes), .txLedN(txLedN), .rxLedN(rxLedN), .colLedN(colLedN),
    .linkLedN(linkLedN), .fdxLedN(fdxLedN)
  );

  phy_led_timers #(
    .STRETCH_CYCLES(STRETCH_CYCLES), .FLASH_CYCLES(FLASH_CYCLES)
  ) timers_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stretchOn(stretchOn),
    .flashDark(flashDark), .flashIdle(flashIdle)
  );
endmodule

// File: rtl/phy_led_checker.sv
module phy_led_checker (
  input logic clk,
  input logic rstN,
  input logic txAct,
  input logic rxAct,
  input logic colAct,
  input logic linkGood,
  input logic fullDuplex,
  input logic polInverted,
  input logic trafficMode,
  input logic polLedMode,
  input logic txLedN,
  input logic rxLedN,
  input logic colLedN,
  input logic linkLedN,
  input logic fdxLedN
);
  assert_reset_dark_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (txLedN && rxLedN && colLedN));

  assert_tx_lit_R2: assert property (@(posedge clk) disable iff (!rstN)
    txAct |=> !txLedN);

  assert_tx_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLedN) |-> $past(txAct));

  assert_rx_lit_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxAct |=> !rxLedN);

  assert_col_lit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (colAct && !fullDuplex) |=> (fullDuplex || !colLedN));

  assert_col_fdx_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    fullDuplex |-> colLedN);

  assert_link_plain_R6: assert property (@(posedge clk) disable iff (!rstN)
    !trafficMode |-> (linkLedN == !linkGood));

  assert_link_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    !linkGood |-> linkLedN);

  assert_dup_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    !polLedMode |-> (fdxLedN == !fullDuplex));

  assert_pol_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    polLedMode |-> (fdxLedN == !polInverted));
endmodule

bind phy_led_ctrl phy_led_checker chk_i (
  .clk(clk), .rstN(rstN), .txAct(txAct), .rxAct(rxAct), .colAct(colAct),
  .linkGood(linkGood), .fullDuplex(fullDuplex), .polInverted(polInverted),
  .trafficMode(trafficMode), .polLedMode(polLedMode), .txLedN(txLedN),
  .rxLedN(rxLedN), .colLedN(colLedN), .linkLedN(linkLedN), .fdxLedN(fdxLedN)
);

// File: tb/phy_led_ctrl_tb.sv
`timescale 1ns/1ps
module phy_led_ctrl_tb_top;
  localparam int ST = 8;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txAct = 0, rxAct = 0, colAct = 0, linkGood = 0, fullDuplex = 0;
  logic polInverted = 0, trafficMode = 0, polLedMode = 0;
  logic txLedN, rxLedN, colLedN, linkLedN, fdxLedN;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference state, written from the requirements
  int mTx = 0, mRx = 0, mCol = 0, mFlash = 0;

  always #2 clk = ~clk;

  phy_led_ctrl #(.STRETCH_CYCLES(ST), .FLASH_CYCLES(FL)) dut_i (
    .clk(clk), .rstN(rstN), .txAct(txAct), .rxAct(rxAct), .colAct(colAct),
    .linkGood(linkGood), .fullDuplex(fullDuplex), .polInverted(polInverted),
    .trafficMode(trafficMode), .polLedMode(polLedMode), .txLedN(txLedN),
    .rxLedN(rxLedN), .colLedN(colLedN), .linkLedN(linkLedN), .fdxLedN(fdxLedN)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTx = 0; mRx = 0; mCol = 0; mFlash = 0;
    end else begin
      mTx = txAct ? ST : (mTx > 0 ? mTx - 1 : 0);
      mRx = rxAct ? ST : (mRx > 0 ? mRx - 1 : 0);
      mCol = (colAct && !fullDuplex) ? ST : (mCol > 0 ? mCol - 1 : 0);
      if (trafficMode && linkGood && (txAct || rxAct) && mFlash == 0) mFlash = 2 * FL;
      else if (mFlash > 0) mFlash = mFlash - 1;
    end
  end

  function automatic logic expTx(); return !(mTx > 0); endfunction
  function automatic logic expRx(); return !(mRx > 0); endfunction
  function automatic logic expCol(); return !(mCol > 0 && !fullDuplex); endfunction
  function automatic logic expLink();
    if (trafficMode) return !(linkGood && !(mFlash > FL));
    return !linkGood;
  endfunction
  function automatic logic expFdx();
    return polLedMode ? !polInverted : !fullDuplex;
  endfunction

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check("R2/R4 tx", txLedN, expTx());
    check("R3/R4 rx", rxLedN, expRx());
    check("R5 col", colLedN, expCol());
    check(trafficMode ? "R7/R8 link" : "R6 link", linkLedN, expLink());
    check(polLedMode ? "R10 fdx" : "R9 fdx", fdxLedN, expFdx());
  endtask

  // one cycle: compare away from the edge, then change inputs
  task automatic step();
    @(negedge clk);
    checkAll();
  endtask

  task automatic idleInputs();
    txAct = 0; rxAct = 0; colAct = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ED5));
    repeat (3) @(negedge clk);
    // R1: outputs dark during reset
    check("R1 tx", txLedN, 1'b1);
    check("R1 rx", rxLedN, 1'b1);
    check("R1 col", colLedN, 1'b1);
    rstN = 1'b1;
    step();
    check("R1 tx after", txLedN, 1'b1);

    // R2: single-cycle tx pulse, exact on-time
    txAct = 1; step(); txAct = 0;
    for (int i = 0; i < ST + 3; i++) step();

    // R3 and R4: retrigger one cycle before expiry
    rxAct = 1; step(); rxAct = 0;
    for (int i = 0; i < ST - 2; i++) step();
    rxAct = 1; step(); rxAct = 0;
    for (int i = 0; i < ST + 2; i++) step();
    check("R4 rx expired", rxLedN, 1'b1);

    // R5: collision ignored in full duplex, stretched in half duplex
    fullDuplex = 1; colAct = 1; step(); colAct = 0;
    step();
    check("R5 col in fdx", colLedN, 1'b1);
    fullDuplex = 0; step();
    check("R5 col no stretch", colLedN, 1'b1);
    colAct = 1; step(); colAct = 0;
    check("R5 col lit", colLedN, 1'b0);
    fullDuplex = 1; step();
    check("R5 col forced off", colLedN, 1'b1);
    fullDuplex = 0;
    for (int i = 0; i < ST + 2; i++) step();

    // R6: plain link
    linkGood = 1; step();
    check("R6 link on", linkLedN, 1'b0);
    // R7: single flash
    trafficMode = 1; step();
    txAct = 1; step(); txAct = 0;
    check("R7 dark", linkLedN, 1'b1);
    rxAct = 1; step(); rxAct = 0;
    for (int i = 0; i < 2 * FL + 3; i++) step();
    check("R7 back on", linkLedN, 1'b0);

    // R8: held activity blinks
    txAct = 1;
    for (int i = 0; i < 5 * (2 * FL + 1); i++) step();
    txAct = 0;
    for (int i = 0; i < 2 * FL + 2; i++) step();

    // R9/R10: duplex pin modes
    fullDuplex = 1; polInverted = 0; polLedMode = 0; step();
    check("R9 fdx lit", fdxLedN, 1'b0);
    polLedMode = 1; step();
    check("R10 pol clear", fdxLedN, 1'b1);
    polInverted = 1; step();
    check("R10 pol lit", fdxLedN, 1'b0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      txAct = ($urandom % 6) == 0;
      rxAct = ($urandom % 5) == 0;
      colAct = ($urandom % 7) == 0;
      if (($urandom % 40) == 0) linkGood = ~linkGood;
      if (($urandom % 30) == 0) fullDuplex = ~fullDuplex;
      if (($urandom % 50) == 0) trafficMode = ~trafficMode;
      if (($urandom % 50) == 0) polLedMode = ~polLedMode;
      if (($urandom % 20) == 0) polInverted = ~polInverted;
      step();
    end
    idleInputs();
    for (int i = 0; i < ST + 2 * FL + 4; i++) step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule